// File: doc/BRIEF.md
# Patchable Array-Reduction Datapath

This block is a small specialized engine for one computation: it walks a region of memory and folds the words it reads into a single accumulated value. Every constant and every operator in that computation is programmable, so a later version of the algorithm can still be mapped onto it. The constants are the address step, the element mask and the starting value of the accumulator. The operators are the mask operation, the direction of the address step, the direction of accumulation and the loop-exit relation. Configuration lives in one serial shift register. The host loads it and reads it back through a single-bit scan port. After reset it holds values that give a plain sum over consecutive words.

The host calls the block like a function. It presents a base address and a length, pulses `start`, and waits for a one-cycle `done` with the result. If the configuration marks the region as unsupported, or holds an operator code the units cannot perform, the block does not compute. It answers at once with `done` and `exc` together, and the host runs the region in software. Element reads go through a simple request/ready port that may stall, like a shared data cache.

Top module: `patch_slice`

## Requirements
- R1: The configuration is a 104-bit shift register. While `scan_en` is high, each clock shifts it left by one: `scan_in` enters bit 0, and `scan_out` always shows bit 103. A full load therefore takes the new image MSB-first and returns the old image MSB-first. The field layout from MSB down is: trap bit [103], relation [102:100], mask operation [99:98], step-negate [97], accumulate-negate [96], stride [95:64], mask [63:32], seed [31:0]. While `scan_en` is low the configuration does not change.
- R2: `start` has no effect while `scan_en` is high. No read is issued and no `done` follows.
- R3: After reset the configuration is: trap 0, relation GE (5), mask operation AND (0), both negate bits 0, stride 1, mask all ones, seed 0. A call with base B and length N then returns the sum of the words at B..B+N-1.
- R4: A call starts with index i=0, address = base and accumulator = seed. Before each read the block evaluates relation(i, len). If it is true the call finishes. Otherwise it reads the word at the current address, then increments i and moves the address by plus or minus stride (minus when step-negate is 1).
- R5: Before accumulation, each word is combined with the mask constant. The mask operation code selects how: 0 = AND, 1 = OR, 2 = XOR.
- R6: The accumulator adds each masked word, or subtracts it when accumulate-negate is 1. Arithmetic is modulo 2^32.
- R7: The relation code selects a signed comparison of i against len: 0 = EQ, 1 = NE, 2 = LT, 3 = LE, 4 = GT, 5 = GE.
- R8: `done` is high for exactly one cycle per accepted call. `result` takes the final accumulator in that cycle and holds it until the next normal completion.
- R9: A call is trapped if the trap bit is 1, the relation code is 6 or 7, or the mask operation code is 3. In that case `done` and `exc` are both high in the cycle after `start`, no read is issued, and `result` keeps its previous value. `exc` is low on every other `done`.
- R10: At most one read is issued per cycle. A read completes in a cycle where `mem_req` and `mem_ready` are both high, so with `mem_ready` held high one word is consumed every cycle. While `mem_req` is high and `mem_ready` is low, `mem_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Call request, sampled while idle |
| arg_base | input | 32 | First element address |
| arg_len | input | 32 | Loop bound compared against the index |
| done | output | 1 | One-cycle completion pulse |
| exc | output | 1 | With done: region must run in software |
| result | output | 32 | Final accumulator value |
| scan_en | input | 1 | Shift the configuration chain |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Serial configuration output (chain MSB) |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_ready | input | 1 | Read accepted, data valid this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume the host never raises `scan_en` while a call is in progress. Configuration is therefore constant for the whole of a call. They also assume `mem_rdata` is valid in every cycle where `mem_ready` is high. The stimulus shifts configuration only between calls, and it waits for `done` before touching the scan port again. The bench memory returns a word computed from the address in the same cycle, and can either hold `mem_ready` high or toggle it to insert stalls.

// File: rtl/patch_slice_pkg.sv
package patch_slice_pkg;

    localparam int CW = 32;

    typedef enum logic [2:0] {
        REL_EQ   = 3'd0,
        REL_NE   = 3'd1,
        REL_LT   = 3'd2,
        REL_LE   = 3'd3,
        REL_GT   = 3'd4,
        REL_GE   = 3'd5,
        REL_BADA = 3'd6,
        REL_BADB = 3'd7
    } rel_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_BAD = 2'd3
    } bw_e;

    typedef struct packed {
        logic            trap;
        rel_e            rel;
        bw_e             bw;
        logic            step_neg;
        logic            acc_neg;
        logic [CW-1:0]   stride;
        logic [CW-1:0]   mask;
        logic [CW-1:0]   seed;
    } cfg_t;

    localparam int CFG_BITS = $bits(cfg_t);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c.trap     = 1'b0;
        c.rel      = REL_GE;
        c.bw       = BW_AND;
        c.step_neg = 1'b0;
        c.acc_neg  = 1'b0;
        c.stride   = CW'(1);
        c.mask     = '1;
        c.seed     = '0;
        return c;
    endfunction

    function automatic logic cfg_unsupported(cfg_t c);
        return c.trap || (c.rel == REL_BADA) || (c.rel == REL_BADB) || (c.bw == BW_BAD);
    endfunction

endpackage

// File: rtl/patch_slice_cfg.sv
module patch_slice_cfg
    import patch_slice_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic shift_in,
    output logic shift_out,
    output cfg_t cfg
);
    localparam int TOPBIT = CFG_BITS - 1;

    logic [CFG_BITS-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= cfg_default();
        else if (shift_en)
            chain <= {chain[TOPBIT-1:0], shift_in};
    end

    assign shift_out = chain[TOPBIT];
    assign cfg       = cfg_t'(chain);

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(chain));

endmodule

// File: rtl/patch_slice_addsub.sv
module patch_slice_addsub #(
    parameter int W = 32
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;

    assign b_eff = sub ? ~b : b;
    assign y     = a + b_eff + W'(sub);

endmodule

// File: rtl/patch_slice_bitwise.sv
module patch_slice_bitwise
    import patch_slice_pkg::*;
#(
    parameter int W = 32
) (
    input  bw_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            BW_AND:  y = a & b;
            BW_OR:   y = a | b;
            BW_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/patch_slice_cmp.sv
module patch_slice_cmp
    import patch_slice_pkg::*;
#(
    parameter int W = 32
) (
    input  rel_e         rel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         hit
);
    logic eq, lt;

    assign eq = (a == b);
    assign lt = ($signed(a) < $signed(b));

    always_comb begin
        unique case (rel)
            REL_EQ:  hit = eq;
            REL_NE:  hit = !eq;
            REL_LT:  hit = lt;
            REL_LE:  hit = lt || eq;
            REL_GT:  hit = !(lt || eq);
            REL_GE:  hit = !lt;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/patch_slice.sv
module patch_slice
    import patch_slice_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] arg_base,
    input  logic [CW-1:0] arg_len,
    output logic          done,
    output logic          exc,
    output logic [CW-1:0] result,
    input  logic          scan_en,
    input  logic          scan_in,
    output logic          scan_out,
    output logic          mem_req,
    output logic [CW-1:0] mem_addr,
    input  logic          mem_ready,
    input  logic [CW-1:0] mem_rdata
);
    cfg_t          cfg;
    state_e        state;
    logic [CW-1:0] addr_q, cnt_q, len_q, acc_q;
    logic [CW-1:0] masked, acc_nxt, addr_nxt;
    logic          stop, launch;

    patch_slice_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (scan_en),
        .shift_in (scan_in),
        .shift_out(scan_out),
        .cfg      (cfg)
    );

    patch_slice_cmp #(.W(CW)) u_exit (
        .rel(cfg.rel),
        .a  (cnt_q),
        .b  (len_q),
        .hit(stop)
    );

    patch_slice_bitwise #(.W(CW)) u_mask (
        .op(cfg.bw),
        .a (mem_rdata),
        .b (cfg.mask),
        .y (masked)
    );

    patch_slice_addsub #(.W(CW)) u_acc (
        .sub(cfg.acc_neg),
        .a  (acc_q),
        .b  (masked),
        .y  (acc_nxt)
    );

    patch_slice_addsub #(.W(CW)) u_step (
        .sub(cfg.step_neg),
        .a  (addr_q),
        .b  (cfg.stride),
        .y  (addr_nxt)
    );

    assign launch   = start && !scan_en && (state == ST_IDLE);
    assign mem_req  = (state == ST_RUN) && !stop;
    assign mem_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done   <= 1'b0;
            exc    <= 1'b0;
            result <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
            len_q  <= '0;
            acc_q  <= '0;
        end else begin
            done <= 1'b0;
            exc  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        if (cfg_unsupported(cfg)) begin
                            done <= 1'b1;
                            exc  <= 1'b1;
                        end else begin
                            state  <= ST_RUN;
                            addr_q <= arg_base;
                            cnt_q  <= '0;
                            len_q  <= arg_len;
                            acc_q  <= cfg.seed;
                        end
                    end
                end
                ST_RUN: begin
                    if (stop) begin
                        state  <= ST_IDLE;
                        done   <= 1'b1;
                        result <= acc_q;
                    end else if (mem_ready) begin
                        acc_q  <= acc_nxt;
                        addr_q <= addr_nxt;
                        cnt_q  <= cnt_q + CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    trap_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (launch && cfg_unsupported(cfg)) |=> (done && exc && !mem_req));

    // R9
    exc_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        exc |-> done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R2
    scan_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && scan_en) |=> ((state == ST_IDLE) && !exc));

    // R1
    no_scan_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        !(scan_en && (state == ST_RUN)));

endmodule

// File: tb/tb_patch_slice.sv
module tb_patch_slice;
    import patch_slice_pkg::*;

    typedef struct packed {
        logic [2:0]  rel;
        logic [1:0]  bw;
        logic        sn;
        logic        an;
        logic [31:0] stride;
        logic [31:0] mask;
        logic [31:0] seed;
        logic [31:0] base;
        logic [31:0] len;
        logic        stall;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd5, 2'd0, 1'b0, 1'b0, 32'd1, 32'hFFFF_FFFF, 32'd0,    32'd10,  32'd5, 1'b0}, // R4
        '{3'd5, 2'd0, 1'b0, 1'b0, 32'd1, 32'hFFFF_FFFF, 32'd0,    32'd10,  32'd0, 1'b0}, // R4
        '{3'd5, 2'd0, 1'b0, 1'b0, 32'd1, 32'hFFFF_FFFF, 32'd0,    32'd200, 32'd6, 1'b1}, // R10
        '{3'd5, 2'd0, 1'b1, 1'b0, 32'd3, 32'hFFFF_FFFF, 32'd0,    32'd100, 32'd4, 1'b0}, // R4
        '{3'd5, 2'd2, 1'b0, 1'b1, 32'd1, 32'h0000_00FF, 32'd1000, 32'd5,   32'd3, 1'b0}, // R5 R6
        '{3'd4, 2'd1, 1'b0, 1'b0, 32'd1, 32'h0000_0100, 32'd0,    32'd0,   32'd2, 1'b1}, // R5 R7
        '{3'd0, 2'd0, 1'b0, 1'b0, 32'd2, 32'h0000_FFFF, 32'd0,    32'd40,  32'd3, 1'b0}, // R7
        '{3'd1, 2'd0, 1'b0, 1'b0, 32'd1, 32'hFFFF_FFFF, 32'd77,   32'd40,  32'd3, 1'b0}, // R7
        '{3'd3, 2'd0, 1'b0, 1'b0, 32'd1, 32'hFFFF_FFFF, 32'd5,    32'd40,  32'd5, 1'b0}, // R7
        '{3'd2, 2'd0, 1'b0, 1'b0, 32'd1, 32'hFFFF_FFFF, 32'd9,    32'd40,  32'd1, 1'b0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] arg_base = '0;
    logic [31:0] arg_len = '0;
    logic        done, exc, scan_out, mem_req;
    logic [31:0] result, mem_addr, mem_rdata;
    logic        scan_en = 1'b0;
    logic        scan_in = 1'b0;
    logic        mem_ready;
    logic        stall_mode = 1'b0;
    logic        rdy_r = 1'b1;
    int          total_reads = 0;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] memf(logic [31:0] a);
        return a * 32'd3 + 32'd7;
    endfunction

    assign mem_rdata = memf(mem_addr);
    assign mem_ready = rdy_r;

    always @(negedge clk) rdy_r <= stall_mode ? ~rdy_r : 1'b1;
    always @(posedge clk) if (mem_req && mem_ready) total_reads <= total_reads + 1;

    patch_slice dut (
        .clk(clk), .rst(rst), .start(start), .arg_base(arg_base), .arg_len(arg_len),
        .done(done), .exc(exc), .result(result),
        .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic rel_true(logic [2:0] r, logic [31:0] i, logic [31:0] n);
        case (r)
            3'd0: return i == n;
            3'd1: return i != n;
            3'd2: return $signed(i) <  $signed(n);
            3'd3: return $signed(i) <= $signed(n);
            3'd4: return $signed(i) >  $signed(n);
            3'd5: return $signed(i) >= $signed(n);
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] model(vec_t v, output int n);
        logic [31:0] acc = v.seed;
        logic [31:0] ad = v.base;
        logic [31:0] x;
        n = 0;
        while (!rel_true(v.rel, 32'(n), v.len) && n < 500) begin
            x = memf(ad);
            case (v.bw)
                2'd0: x = x & v.mask;
                2'd1: x = x | v.mask;
                default: x = x ^ v.mask;
            endcase
            acc = v.an ? acc - x : acc + x;
            ad  = v.sn ? ad - v.stride : ad + v.stride;
            n++;
        end
        return acc;
    endfunction

    function automatic logic [103:0] pack_cfg(logic t, vec_t v);
        return {t, v.rel, v.bw, v.sn, v.an, v.stride, v.mask, v.seed};
    endfunction

    task automatic scan_load(input logic [103:0] img, output logic [103:0] old);
        for (int i = 103; i >= 0; i--) begin
            @(negedge clk);
            scan_en = 1'b1;
            scan_in = img[i];
            #0 old[i] = scan_out;
        end
        @(negedge clk);
        scan_en = 1'b0;
    endtask

    task automatic call(input logic [31:0] b, input logic [31:0] n,
                        output logic [31:0] res, output logic ex, output int rd, output bit ok);
        int snap;
        @(negedge clk);
        arg_base = b;
        arg_len  = n;
        start    = 1'b1;
        snap     = total_reads;
        @(negedge clk);
        start = 1'b0;
        ok = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        res = result;
        ex  = exc;
        rd  = total_reads - snap;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] res, prev;
        logic        ex;
        int          rd, n_exp;
        bit          ok;
        logic [103:0] old;
        vec_t        dv;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 reset state
        chk(!done && !exc && !mem_req, "R8 reset", {done, exc, mem_req}, 3'b000);
        chk(result == 0, "R8 reset result", result, 0);

        // R3 default configuration computes a plain sum
        dv = VECS[0];
        call(32'd10, 32'd5, res, ex, rd, ok);
        chk(ok && !ex, "R3 default done", {ok, ex}, 2'b10);
        chk(res == model(dv, n_exp), "R3 default sum", res, model(dv, n_exp));
        chk(rd == 5, "R3 default reads", rd, 5);

        // R1 readback of reset image while loading a new one
        scan_load(pack_cfg(1'b0, VECS[3]), old);
        chk(old == 104'(cfg_default()), "R1 readback default", old, cfg_default());
        scan_load(pack_cfg(1'b0, VECS[3]), old);
        chk(old == pack_cfg(1'b0, VECS[3]), "R1 readback loaded", old, pack_cfg(1'b0, VECS[3]));

        // vector table
        for (int k = 0; k < NV; k++) begin
            logic [31:0] e;
            scan_load(pack_cfg(1'b0, VECS[k]), old);
            stall_mode = VECS[k].stall;
            call(VECS[k].base, VECS[k].len, res, ex, rd, ok);
            stall_mode = 1'b0;
            e = model(VECS[k], n_exp);
            chk(ok && !ex, "R4 R8 vector done", {ok, ex}, 2'b10);
            chk(res == e, "R4 R5 R6 R7 vector result", res, e);
            chk(rd == n_exp, "R10 vector reads", rd, n_exp);
        end

        // R9 trap cases: trap bit, relation 6, relation 7, mask op 3
        for (int t = 0; t < 4; t++) begin
            vec_t v;
            logic tb;
            int   snap;
            v  = VECS[0];
            tb = (t == 0);
            if (t == 1) v.rel = 3'd6;
            if (t == 2) v.rel = 3'd7;
            if (t == 3) v.bw  = 2'd3;
            scan_load(pack_cfg(tb, v), old);
            prev = result;
            @(negedge clk);
            arg_base = 32'd10;
            arg_len  = 32'd5;
            start    = 1'b1;
            snap     = total_reads;
            @(negedge clk);
            start = 1'b0;
            chk(done && exc, "R9 trap response", {done, exc}, 2'b11);
            @(negedge clk);
            chk(!done, "R8 R9 single pulse", done, 0);
            repeat (3) @(negedge clk);
            chk(total_reads == snap && result == prev, "R9 no reads, result kept",
                {total_reads - snap, result}, {32'd0, prev});
        end

        // R2 start ignored while scanning
        scan_load(104'(cfg_default()), old);
        begin
            int snap;
            bit seen;
            seen = 1'b0;
            @(negedge clk);
            snap     = total_reads;
            arg_base = 32'd10;
            arg_len  = 32'd5;
            scan_en  = 1'b1;
            start    = 1'b1;
            @(negedge clk);
            start   = 1'b0;
            scan_en = 1'b0;
            for (int c = 0; c < 10; c++) begin
                if (done || mem_req) seen = 1'b1;
                @(negedge clk);
            end
            chk(!seen && total_reads == snap, "R2 start ignored", seen, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule